// File: doc/BRIEF.md
# Split-Window Cartridge Bank Mapper

This block translates CPU bus addresses that fall inside the 16 KB cartridge window (0xB000 to 0xEFFF) into a physical address. It also produces one-hot chip selects for external cartridge ROM, internal ROM, RAM and the cartridge control port, and a write-allowed signal. The window is not linear. Its low 4 KB (0xB000 to 0xBFFF) lands in the top quarter of the selected 16 KB page, and its high 12 KB (0xC000 to 0xEFFF) lands at the start of that page. Both parts always use the same page number. Addresses outside the window, including the system ROM area at 0xF000 and above, are left to other decoders.

Three control registers are programmed through a small register port: a system register, a cartridge register and a compatibility register. They decide whether the window shows RAM or ROM and which RAM page it shows. In ROM mode the window cannot be written. Instead, a CPU write to any window address is taken as a bank-select command, and the ROM page is taken from the low three address bits. Translation is combinational from the address and the registered state. Every register or bank change becomes visible in the bus cycle after the write.

Top module: `cart_window_map`

## Requirements
- R1: For an address outside 0xB000 to 0xEFFF, all four selects are low, writeOk is low and physAddr is 0.
- R2: An address in 0xB000 to 0xBFFF translates to page base + 0x3000 + (address - 0xB000). The page base is 0x4000 times the page number within the selected source.
- R3: An address in 0xC000 to 0xEFFF translates to page base + (address - 0xC000), using the same page number as R2.
- R4: The window is in RAM mode when either condition holds: system register bit 6 is set and cartridge register bit 5 is set; or system register bit 6 is clear and compatibility register bit 2 is set. In every other state it is in ROM mode. regSel selects the register: 0 is system, 1 is cartridge, 2 is compatibility.
- R5: In RAM mode, ramSel is high. The RAM page is cartridge register bits 2:0 when system bit 6 is set, and compatibility register bits 1:0 otherwise. physAddr is the R2/R3 result ANDed with RAM_INST_PAGES x 0x4000 - 1, so pages beyond installed memory wrap.
- R6: writeOk is high exactly when busWrite is high, the address is in the window, the mode is RAM, and the active write-enable flag is set. That flag is cartridge bit 6 when system bit 6 is set, and compatibility bit 3 otherwise.
- R7: In ROM mode, a bus write in the window loads busAddr bits 2:0 into the ROM page. The new page is used from the next cycle, and writeOk stays low.
- R8: For ROM pages 0 to 3, extRomSel is high and the page base uses bank = page mod CART_BANKS. For ROM pages 4 to 7, intRomSel is high and the page base uses page - 4.
- R9: In external ROM mode, addresses 0xBFFC to 0xBFFF assert ctlSel instead of extRomSel, and physAddr stays at the R2 value.
- R10: Reset (asynchronous, active low) clears all registers and the ROM page. At most one select is ever high.
- R11: A register write takes effect in the cycle after its strobe. A write with regSel = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | CPU address |
| busWrite | input | 1 | CPU write strobe for the current cycle |
| regWrite | input | 1 | Control register write strobe |
| regSel | input | 2 | Register index: 0 system, 1 cartridge, 2 compatibility, 3 unused |
| regData | input | 8 | Control register write data |
| physAddr | output | 17 | Translated physical address within the selected source |
| extRomSel | output | 1 | External cartridge ROM select |
| intRomSel | output | 1 | Internal ROM select |
| ramSel | output | 1 | RAM select |
| ctlSel | output | 1 | Cartridge control port select |
| writeOk | output | 1 | The current write may modify memory |

## Verification
A window write in ROM mode, which captures a bank, can fall in the same clock edge as a control register write that switches the window to RAM. The bench provokes this by raising busWrite at 0xC005 and regWrite to the cartridge register in one cycle. It then checks that the next cycle shows RAM page 1. After the cartridge register is cleared, the window must show internal ROM, which proves that page 5 was still captured. The bench also checks that neither update can be seen before the edge.

// File: rtl/cart_window_map_pkg.sv
package cart_window_map_pkg;
  localparam int PAGE_BITS = 14;
  localparam int RAM_PAGE_BITS = 3;
  localparam int PHYS_W = PAGE_BITS + RAM_PAGE_BITS;
  localparam logic [1:0] REG_SYS = 2'd0;
  localparam logic [1:0] REG_CART = 2'd1;
  localparam logic [1:0] REG_COMPAT = 2'd2;

  typedef struct packed {
    logic ldSys;
    logic ldCart;
    logic ldCompat;
    logic ldBank;
  } mapStrobe_t;
endpackage

// File: rtl/cwm_ctrl.sv
module cwm_ctrl
  import cart_window_map_pkg::*;
(
  input  logic       busWrite,
  input  logic       regWrite,
  input  logic [1:0] regSel,
  input  logic       inWindow,
  input  logic       ramMode,
  input  logic       wrEnable,
  output mapStrobe_t stb,
  output logic       writeOk
);
  always_comb begin
    stb.ldSys    = regWrite && (regSel == REG_SYS);
    stb.ldCart   = regWrite && (regSel == REG_CART);
    stb.ldCompat = regWrite && (regSel == REG_COMPAT);
    // ROM mode: a write into the window is a bank command, not a store
    stb.ldBank   = busWrite && inWindow && !ramMode;
    writeOk      = busWrite && inWindow && ramMode && wrEnable;
  end
endmodule

// File: rtl/cwm_datapath.sv
module cwm_datapath
  import cart_window_map_pkg::*;
#(
  parameter int CART_BANKS = 3,
  parameter int RAM_INST_PAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        stb,
  input  logic [7:0]        regData,
  input  logic [15:0]       busAddr,
  output logic              inWindow,
  output logic              ramMode,
  output logic              wrEnable,
  output logic [PHYS_W-1:0] physAddr,
  output logic              extRomSel,
  output logic              intRomSel,
  output logic              ramSel,
  output logic              ctlSel
);
  localparam logic [PHYS_W-1:0] RAM_MASK = PHYS_W'(RAM_INST_PAGES * (1 << PAGE_BITS) - 1);
  localparam logic [1:0] BANK_COUNT = 2'(CART_BANKS);

  logic [7:0] sysReg, cartReg, compatReg;
  logic [2:0] romPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysReg    <= '0;
      cartReg   <= '0;
      compatReg <= '0;
      romPage   <= '0;
    end else begin
      if (stb.ldSys)    sysReg    <= regData;
      if (stb.ldCart)   cartReg   <= regData;
      if (stb.ldCompat) compatReg <= regData;
      if (stb.ldBank)   romPage   <= busAddr[2:0];
    end
  end

  // mode decode
  logic newMode;
  logic [RAM_PAGE_BITS-1:0] ramPage;
  always_comb begin
    newMode  = sysReg[6];
    ramMode  = newMode ? cartReg[5] : compatReg[2];
    wrEnable = newMode ? cartReg[6] : compatReg[3];
    ramPage  = newMode ? cartReg[2:0] : {1'b0, compatReg[1:0]};
  end

  // external bank wraps on the number of banks fitted
  logic [1:0] extBank;
  generate
    if (CART_BANKS >= 4) begin : g_fullBanks
      assign extBank = romPage[1:0];
    end else begin : g_wrapBanks
      assign extBank = romPage[1:0] % BANK_COUNT;
    end
  endgenerate

  // offsets for the two halves of the window
  logic lowHalf;
  logic [15:0] hiDelta;
  logic [PAGE_BITS-1:0] lowOff, hiOff, winOff;
  always_comb begin
    inWindow = (busAddr[15:12] >= 4'hB) && (busAddr[15:12] <= 4'hE);
    lowHalf  = busAddr[15:12] == 4'hB;
    lowOff   = PAGE_BITS'(14'h3000 + {2'b00, busAddr[11:0]});
    hiDelta  = busAddr - 16'hC000;
    hiOff    = hiDelta[PAGE_BITS-1:0];
    winOff   = lowHalf ? lowOff : hiOff;
  end

  logic isCtlSpot;
  always_comb begin
    isCtlSpot = busAddr[15:2] == 14'h2FFF;
    extRomSel = 1'b0;
    intRomSel = 1'b0;
    ramSel    = 1'b0;
    ctlSel    = 1'b0;
    physAddr  = '0;
    if (inWindow) begin
      if (ramMode) begin
        ramSel   = 1'b1;
        physAddr = {ramPage, winOff} & RAM_MASK;
      end else if (!romPage[2]) begin
        physAddr  = {1'b0, extBank, winOff};
        ctlSel    = isCtlSpot;
        extRomSel = !isCtlSpot;
      end else begin
        intRomSel = 1'b1;
        physAddr  = {1'b0, romPage[1:0], winOff};
      end
    end
  end
endmodule

// File: rtl/cart_window_map.sv
module cart_window_map
  import cart_window_map_pkg::*;
#(
  parameter int CART_BANKS = 3,
  parameter int RAM_INST_PAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       busAddr,
  input  logic              busWrite,
  input  logic              regWrite,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regData,
  output logic [PHYS_W-1:0] physAddr,
  output logic              extRomSel,
  output logic              intRomSel,
  output logic              ramSel,
  output logic              ctlSel,
  output logic              writeOk
);
  mapStrobe_t stb;
  logic inWindow, ramMode, wrEnable;

  cwm_ctrl u_ctrl (
    .busWrite(busWrite), .regWrite(regWrite), .regSel(regSel),
    .inWindow(inWindow), .ramMode(ramMode), .wrEnable(wrEnable),
    .stb(stb), .writeOk(writeOk)
  );

  cwm_datapath #(.CART_BANKS(CART_BANKS), .RAM_INST_PAGES(RAM_INST_PAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regData(regData), .busAddr(busAddr),
    .inWindow(inWindow), .ramMode(ramMode), .wrEnable(wrEnable),
    .physAddr(physAddr), .extRomSel(extRomSel), .intRomSel(intRomSel),
    .ramSel(ramSel), .ctlSel(ctlSel)
  );
endmodule

// File: rtl/cart_window_map_chk.sv
module cart_window_map_chk
  import cart_window_map_pkg::*;
#(
  parameter int RAM_INST_PAGES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       busAddr,
  input logic              busWrite,
  input logic              regWrite,
  input logic [PHYS_W-1:0] physAddr,
  input logic              extRomSel,
  input logic              intRomSel,
  input logic              ramSel,
  input logic              ctlSel,
  input logic              writeOk
);
  localparam logic [PHYS_W-1:0] MASK = PHYS_W'(RAM_INST_PAGES * (1 << PAGE_BITS) - 1);
  logic outside;
  assign outside = (busAddr < 16'hB000) || (busAddr > 16'hEFFF);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({extRomSel, intRomSel, ramSel, ctlSel})); // R10
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    outside |-> (!extRomSel && !intRomSel && !ramSel && !ctlSel && !writeOk && physAddr == '0)); // R1
  AST_WRITE_RAM_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    writeOk |-> (ramSel && busWrite)); // R6
  AST_RAM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> (physAddr <= MASK)); // R5
  AST_LOW_TOP_QUARTER: assert property (@(posedge clk) disable iff (!rstN)
    ((ramSel || extRomSel || intRomSel || ctlSel) && busAddr[15:12] == 4'hB) |-> (physAddr[13:12] == 2'b11)); // R2
  AST_CTL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctlSel |-> (busAddr[15:2] == 14'h2FFF)); // R9
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && !regWrite) |=> ((busAddr != $past(busAddr)) || $stable(physAddr))); // R11
endmodule

bind cart_window_map cart_window_map_chk #(.RAM_INST_PAGES(RAM_INST_PAGES)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite), .regWrite(regWrite),
  .physAddr(physAddr), .extRomSel(extRomSel), .intRomSel(intRomSel), .ramSel(ramSel),
  .ctlSel(ctlSel), .writeOk(writeOk)
);

// File: tb/cart_window_map_test.sv
`timescale 1ns/1ps
module cart_window_map_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busWrite = 1'b0, regWrite = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regData = '0;
  logic [16:0] physAddr;
  logic extRomSel, intRomSel, ramSel, ctlSel, writeOk;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_window_map #(.CART_BANKS(3), .RAM_INST_PAGES(4)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .regWrite(regWrite), .regSel(regSel), .regData(regData), .physAddr(physAddr),
    .extRomSel(extRomSel), .intRomSel(intRomSel), .ramSel(ramSel),
    .ctlSel(ctlSel), .writeOk(writeOk)
  );

  typedef struct packed {
    logic [2:0]  rp;
    logic [7:0]  sys;
    logic [7:0]  cart;
    logic [7:0]  compat;
    logic [15:0] addr;
    logic        wr;
    logic [3:0]  sel;   // {ext, int, ram, ctl}
    logic [16:0] phys;
    logic        wok;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h00, 8'h00, 8'h00, 16'hB000, 1'b0, 4'b1000, 17'h03000, 1'b0}, // R2 ext page 0
    '{3'd0, 8'h00, 8'h00, 8'h00, 16'hE123, 1'b0, 4'b1000, 17'h02123, 1'b0}, // R3
    '{3'd2, 8'h00, 8'h00, 8'h00, 16'hBFFC, 1'b0, 4'b0001, 17'h0BFFC, 1'b0}, // R9 control spot
    '{3'd3, 8'h00, 8'h00, 8'h00, 16'hBFFD, 1'b0, 4'b0001, 17'h03FFD, 1'b0}, // R9 with R8 wrap
    '{3'd3, 8'h00, 8'h00, 8'h00, 16'hC010, 1'b0, 4'b1000, 17'h00010, 1'b0}, // R8 3 mod 3 = 0
    '{3'd5, 8'h00, 8'h00, 8'h00, 16'hB800, 1'b0, 4'b0100, 17'h07800, 1'b0}, // R8 internal
    '{3'd5, 8'h00, 8'h00, 8'h00, 16'hBFFC, 1'b0, 4'b0100, 17'h07FFC, 1'b0}, // R9 not in internal
    '{3'd7, 8'h00, 8'h00, 8'h00, 16'hD001, 1'b0, 4'b0100, 17'h0D001, 1'b0}, // R8 R3
    '{3'd0, 8'h40, 8'h63, 8'h00, 16'hB004, 1'b1, 4'b0010, 17'h0F004, 1'b1}, // R4 R5 R6 new mode
    '{3'd0, 8'h40, 8'h25, 8'h00, 16'hC100, 1'b1, 4'b0010, 17'h04100, 1'b0}, // R5 wrap, R6 no enable
    '{3'd0, 8'h00, 8'h20, 8'h0E, 16'hE000, 1'b1, 4'b0010, 17'h0A000, 1'b1}, // R4 R5 R6 compat
    '{3'd0, 8'h40, 8'h00, 8'h04, 16'hC000, 1'b0, 4'b1000, 17'h00000, 1'b0}, // R4 compat bit unused
    '{3'd1, 8'h00, 8'h00, 8'h00, 16'hD000, 1'b1, 4'b1000, 17'h05000, 1'b0}, // R7 ROM write blocked
    '{3'd0, 8'h00, 8'h60, 8'h04, 16'hBFFF, 1'b1, 4'b0010, 17'h03FFF, 1'b0}, // R6 compat no enable
    '{3'd0, 8'h40, 8'h60, 8'h00, 16'hA000, 1'b1, 4'b0000, 17'h00000, 1'b0}, // R1 below
    '{3'd0, 8'h00, 8'h00, 8'h00, 16'hF000, 1'b0, 4'b0000, 17'h00000, 1'b0}, // R1 above
    '{3'd0, 8'h40, 8'h60, 8'h00, 16'hEFFF, 1'b0, 4'b0010, 17'h02FFF, 1'b0}  // R3 R6 read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    regSel = s; regData = d; regWrite = 1'b1;
    @(posedge clk); #1;
    regWrite = 1'b0;
  endtask

  task automatic busWr(input logic [15:0] a);
    @(negedge clk);
    busAddr = a; busWrite = 1'b1;
    @(posedge clk); #1;
    busWrite = 1'b0;
  endtask

  function automatic logic [3:0] sels();
    return {extRomSel, intRomSel, ramSel, ctlSel};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    busAddr = 16'hB000; #1;
    check("R10 reset sel", 32'(sels()), 32'(4'b1000));
    check("R10 reset phys", 32'(physAddr), 32'h3000);

    for (int i = 0; i < NV; i++) begin
      writeReg(2'd0, 8'h00); writeReg(2'd1, 8'h00); writeReg(2'd2, 8'h00);
      busWr(16'hC000 | 16'(VECS[i].rp));
      writeReg(2'd0, VECS[i].sys);
      writeReg(2'd1, VECS[i].cart);
      writeReg(2'd2, VECS[i].compat);
      @(negedge clk);
      busAddr = VECS[i].addr; busWrite = VECS[i].wr; #1;
      check($sformatf("R1-R9 vec%0d sel", i), 32'(sels()), 32'(VECS[i].sel));
      check($sformatf("R2 R3 R5 vec%0d phys", i), 32'(physAddr), 32'(VECS[i].phys));
      check($sformatf("R6 vec%0d writeOk", i), 32'(writeOk), 32'(VECS[i].wok));
      @(posedge clk); #1; busWrite = 1'b0;
    end

    // R7: bank capture visible only after the edge
    writeReg(2'd0, 8'h00); writeReg(2'd1, 8'h00); writeReg(2'd2, 8'h00);
    busWr(16'hC000);
    @(negedge clk); busAddr = 16'hC002; busWrite = 1'b1; #1;
    check("R7 before edge", 32'(physAddr), 32'h00002);
    @(posedge clk); #1; busWrite = 1'b0; #1;
    check("R7 after edge", 32'(physAddr), 32'h08002);

    // R11: register write visible only after the edge; regSel 3 ignored
    writeReg(2'd0, 8'h40);
    @(negedge clk); regSel = 2'd1; regData = 8'h60; regWrite = 1'b1; #1;
    check("R11 before edge", 32'(ramSel), 32'd0);
    @(posedge clk); #1; regWrite = 1'b0; #1;
    check("R11 after edge", 32'(sels()), 32'(4'b0010));
    writeReg(2'd3, 8'hFF);
    #1;
    check("R11 sel3 ignored sel", 32'(sels()), 32'(4'b0010));
    check("R11 sel3 ignored phys", 32'(physAddr), 32'h00002);

    // R7 with R11: bank capture and register write on the same edge
    writeReg(2'd1, 8'h00);
    @(negedge clk);
    busAddr = 16'hC005; busWrite = 1'b1;
    regSel = 2'd1; regData = 8'h61; regWrite = 1'b1;
    @(posedge clk); #1; busWrite = 1'b0; regWrite = 1'b0; #1;
    check("R11 same-cycle ram sel", 32'(sels()), 32'(4'b0010));
    check("R11 same-cycle ram phys", 32'(physAddr), 32'h04005);
    writeReg(2'd1, 8'h00);
    #1;
    check("R7 same-cycle captured sel", 32'(sels()), 32'(4'b0100));
    check("R7 same-cycle captured phys", 32'(physAddr), 32'h04005);

    // R10: reset in the middle of a run
    writeReg(2'd1, 8'h61);
    @(negedge clk); busAddr = 16'hB000; rstN = 1'b0; #1;
    check("R10 mid reset sel", 32'(sels()), 32'(4'b1000));
    check("R10 mid reset phys", 32'(physAddr), 32'h03000);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule